// File: doc/BRIEF.md
# Paged Audio Controller Register Window

This block is the host-side register file of a three-channel audio DMA controller. There are two playback channels, called DAC1 and DAC2, and one capture channel, called ADC. The host bus presents an address, an access size (byte, halfword or word), separate read and write strobes and right-justified write data. Byte and halfword writes change only the lanes they address. Read data comes back one cycle after the read strobe.

A small page register extends the address space. Any offset from 0x30 to 0x3F is combined with that page, which opens per-channel frame address and frame count registers at 0xC30–0xC3F and 0xD30–0xD3F.

The control word and the serial control word go out on ports to the channel engines. Each engine returns a one-cycle completion pulse. The block turns those pulses into pending bits, gathers the pending bits into a status word with a summary bit, and drives a level interrupt line.

Top module: `audio_regwin`

## Requirements
- R1: Only address bits [7:0] are decoded. When those bits fall in 0x30–0x3F, the 4-bit page value shifted left by 8 is ORed in to form the effective 12-bit address. Otherwise the effective address is the 8-bit offset itself.
- R2: After reset:
  - control reads 0x00000001 and status reads 0x00000060.
  - page, codec and serial control read zero.
  - irq is low.
- R3: The size code is 0 for byte, 1 for halfword and 2 for word, and write data is right-justified.
  - A byte write to 0x00–0x03 (control) or 0x20–0x23 (serial control) replaces only the addressed byte lane.
  - A halfword write to 0x00 or 0x02 replaces only the low or the high half of control.
  - A word write to 0x00 or 0x20 replaces the whole register.
  - Control and serial control change only on such writes.
- R4: A byte or word write to 0x0C keeps only bits [3:0] as the page.
- R5: Word accesses to the frame registers:
  - 0xC30/0xC34 are the DAC1 frame address and count.
  - 0xC38/0xC3C are the same pair for DAC2.
  - 0xD30/0xD34 are the same pair for ADC.
  - Halfword reads of a count register return its low half at the base address and its high half at base+2.
  - 0xD38/0xD3C read as all ones, and writes to them change nothing.
- R6: The status word has the following bits:
  - bit 31 is the OR of the pending bits.
  - bit 2 is the DAC1 pending bit, bit 1 the DAC2 pending bit and bit 0 the ADC pending bit.
  - bits 6:5 read as ones.
  - every other bit reads as zero.
  - irq equals bit 31.
- R7: chan_done bit 0 belongs to DAC1, bit 1 to DAC2 and bit 2 to ADC. A pulse sets the channel's pending bit at the next edge only while that channel's enable is set in serial control: bit 8 for DAC1, bit 9 for DAC2, bit 10 for ADC. A set wins over a same-cycle clear.
- R8: A serial control write that turns an enable bit from 1 to 0 clears that channel's pending bit. Nothing else clears a pending bit.
- R9: Reads behave as follows:
  - bus_rdata updates on the edge after a read strobe and holds otherwise.
  - Byte and halfword reads return the lane zero-extended.
  - A byte read of 0x1B returns 5.
  - Byte reads of 0x00–0x07 return control or status lanes.
  - A byte read of 0x0C returns the page.
  - Any unmapped address or size returns all ones.
- R10: A halfword or word write to 0x24, 0x28 or 0x2C (DAC1, DAC2, ADC sample count) stores data bits [15:0]. A word read there returns the count zero-extended. A halfword read at base+2 returns zero.
- R11: A halfword write to 0x10 stores data bits [15:0] as the codec word, which a word read returns zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Host byte address |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Right-justified write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| irq | output | 1 | Interrupt, OR of pending bits |
| ctl_out | output | 32 | Control register to the channel engines |
| sctl_out | output | 32 | Serial control register to the channel engines |
| chan_done | input | 3 | Completion pulses: 0 DAC1, 1 DAC2, 2 ADC |

## Verification
A wrong lane merge or a wrong page decode shows on ctl_out, on sctl_out or in the next read word. Both outputs are compared against the model at every clock, so such an error is seen one cycle after the faulty write.

A pending bit held in the wrong state shows on irq at the very next edge. It also shows in status bit 31 and in the channel bit on the following read.

The set-versus-clear race and the clear-only-on-a-falling-enable rule are each driven on purpose. Getting either one wrong therefore leaves irq different from the model in a known cycle.

// File: rtl/audio_regwin.sv
module audio_regwin #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [31:0]       ctl_out,
  output logic [31:0]       sctl_out,
  input  logic [2:0]        chan_done
);
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;
  localparam int         NCH  = 3;

  logic [31:0] ctl, sctl, ctl_nx, sctl_nx, codec, status, rd_val;
  logic [3:0]  page;
  logic [2:0]  pend, en_old, en_new;
  logic [15:0] scnt [NCH];
  logic [31:0] faddr [NCH];
  logic [31:0] fcnt [NCH];
  logic [7:0]  off;
  logic [11:0] ea;
  logic        addr_unused;

  assign addr_unused = ^bus_addr[ADDR_W-1:8];
  assign off = bus_addr[7:0];
  assign ea  = (off[7:4] == 4'h3) ? {page, off} : {4'h0, off};

  assign status   = {|pend, 24'h0, 2'b11, 2'b00, pend[0], pend[1], pend[2]};
  assign irq      = status[31];
  assign ctl_out  = ctl;
  assign sctl_out = sctl;
  assign en_old   = sctl[10:8];
  assign en_new   = sctl_nx[10:8];

  always_comb begin
    ctl_nx  = ctl;
    sctl_nx = sctl;
    if (bus_wr) begin
      case (bus_size)
        SZ_B: begin
          if (ea[11:2] == 10'h000) ctl_nx[{ea[1:0], 3'b000} +: 8] = bus_wdata[7:0];
          if (ea[11:2] == 10'h008) sctl_nx[{ea[1:0], 3'b000} +: 8] = bus_wdata[7:0];
        end
        SZ_H: begin
          if (ea == 12'h000) ctl_nx[15:0]  = bus_wdata[15:0];
          if (ea == 12'h002) ctl_nx[31:16] = bus_wdata[15:0];
        end
        SZ_W: begin
          if (ea == 12'h000) ctl_nx  = bus_wdata;
          if (ea == 12'h020) sctl_nx = bus_wdata;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl   <= 32'h1;
      sctl  <= '0;
      page  <= '0;
      codec <= '0;
      pend  <= '0;
      for (int i = 0; i < NCH; i++) begin
        scnt[i]  <= '0;
        faddr[i] <= '0;
        fcnt[i]  <= '0;
      end
    end else begin
      ctl  <= ctl_nx;
      sctl <= sctl_nx;
      pend <= (pend & ~(en_old & ~en_new)) | (chan_done & en_old);
      if (bus_wr) begin
        if ((bus_size == SZ_B || bus_size == SZ_W) && ea == 12'h00C) page <= bus_wdata[3:0];
        if (bus_size == SZ_H && ea == 12'h010) codec <= {16'h0, bus_wdata[15:0]};
        if (bus_size == SZ_H || bus_size == SZ_W) begin
          case (ea)
            12'h024: scnt[0] <= bus_wdata[15:0];
            12'h028: scnt[1] <= bus_wdata[15:0];
            12'h02C: scnt[2] <= bus_wdata[15:0];
            default: ;
          endcase
        end
        if (bus_size == SZ_W) begin
          case (ea)
            12'hC30: faddr[0] <= bus_wdata;
            12'hC34: fcnt[0]  <= bus_wdata;
            12'hC38: faddr[1] <= bus_wdata;
            12'hC3C: fcnt[1]  <= bus_wdata;
            12'hD30: faddr[2] <= bus_wdata;
            12'hD34: fcnt[2]  <= bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_val = '1;
    case (bus_size)
      SZ_B: begin
        if (ea == 12'h01B) rd_val = 32'd5;
        else if (ea == 12'h00C) rd_val = {28'h0, page};
        else if (ea[11:2] == 10'h000) rd_val = {24'h0, ctl[{ea[1:0], 3'b000} +: 8]};
        else if (ea[11:2] == 10'h001) rd_val = {24'h0, status[{ea[1:0], 3'b000} +: 8]};
      end
      SZ_H: begin
        case (ea)
          12'h026, 12'h02A, 12'h02E: rd_val = '0;
          12'hC34: rd_val = {16'h0, fcnt[0][15:0]};
          12'hC36: rd_val = {16'h0, fcnt[0][31:16]};
          12'hC3C: rd_val = {16'h0, fcnt[1][15:0]};
          12'hC3E: rd_val = {16'h0, fcnt[1][31:16]};
          12'hD34: rd_val = {16'h0, fcnt[2][15:0]};
          12'hD36: rd_val = {16'h0, fcnt[2][31:16]};
          default: ;
        endcase
      end
      SZ_W: begin
        case (ea)
          12'h000: rd_val = ctl;
          12'h004: rd_val = status;
          12'h00C: rd_val = {28'h0, page};
          12'h010: rd_val = codec;
          12'h020: rd_val = sctl;
          12'h024: rd_val = {16'h0, scnt[0]};
          12'h028: rd_val = {16'h0, scnt[1]};
          12'h02C: rd_val = {16'h0, scnt[2]};
          12'hC30: rd_val = faddr[0];
          12'hC34: rd_val = fcnt[0];
          12'hC38: rd_val = faddr[1];
          12'hC3C: rd_val = fcnt[1];
          12'hD30: rd_val = faddr[2];
          12'hD34: rd_val = fcnt[2];
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

module audio_regwin_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [31:0] bus_rdata,
  input logic        irq,
  input logic [31:0] ctl_out,
  input logic [31:0] sctl_out,
  input logic [2:0]  chan_done
);
  a_r3_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(ctl_out));
  a_r3_sctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(sctl_out));
  a_r7_irq_rise_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(chan_done & sctl_out[10:8])) |=> !$rose(irq));
  a_r8_irq_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> !$fell(irq));
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind audio_regwin audio_regwin_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .irq(irq), .ctl_out(ctl_out),
  .sctl_out(sctl_out), .chan_done(chan_done)
);

// File: tb/audio_regwin_bench.sv
module audio_regwin_bench;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [15:0] bus_addr = 0;
  logic [1:0]  bus_size = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [31:0] ctl_out, sctl_out;
  logic [2:0]  chan_done = 0;

  integer n_run = 0, n_fail = 0;
  bit     finished = 0;

  logic [31:0] m_ctl = 1, m_sctl = 0, m_codec = 0;
  logic [3:0]  m_page = 0;
  logic [2:0]  m_pend = 0;
  logic [15:0] m_sc [3];
  logic [31:0] m_fa [3];
  logic [31:0] m_fc [3];

  audio_regwin u_audio_regwin (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .ctl_out(ctl_out),
    .sctl_out(sctl_out), .chan_done(chan_done)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int eff(input logic [15:0] a);
    int o;
    o = a & 255;
    if (o >= 'h30 && o <= 'h3F) return o | (int'(m_page) << 8);
    return o;
  endfunction

  function automatic logic [31:0] m_status();
    return {(m_pend != 0), 24'h0, 2'b11, 2'b00, m_pend[0], m_pend[1], m_pend[2]};
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] sz, input logic [15:0] a);
    int e;
    logic [31:0] st;
    e  = eff(a);
    st = m_status();
    if (sz == 0) begin
      if (e == 'h1B) return 5;
      if (e == 'h0C) return {28'h0, m_page};
      if (e < 4)     return (m_ctl >> (8 * e)) & 32'hFF;
      if (e < 8)     return (st >> (8 * (e - 4))) & 32'hFF;
    end else if (sz == 1) begin
      if (e == 'h26 || e == 'h2A || e == 'h2E) return 0;
      if (e == 'hC34) return m_fc[0] & 32'hFFFF;
      if (e == 'hC36) return m_fc[0] >> 16;
      if (e == 'hC3C) return m_fc[1] & 32'hFFFF;
      if (e == 'hC3E) return m_fc[1] >> 16;
      if (e == 'hD34) return m_fc[2] & 32'hFFFF;
      if (e == 'hD36) return m_fc[2] >> 16;
    end else if (sz == 2) begin
      if (e == 0)     return m_ctl;
      if (e == 4)     return st;
      if (e == 'h0C)  return {28'h0, m_page};
      if (e == 'h10)  return m_codec;
      if (e == 'h20)  return m_sctl;
      if (e == 'h24)  return {16'h0, m_sc[0]};
      if (e == 'h28)  return {16'h0, m_sc[1]};
      if (e == 'h2C)  return {16'h0, m_sc[2]};
      if (e == 'hC30) return m_fa[0];
      if (e == 'hC34) return m_fc[0];
      if (e == 'hC38) return m_fa[1];
      if (e == 'hC3C) return m_fc[1];
      if (e == 'hD30) return m_fa[2];
      if (e == 'hD34) return m_fc[2];
    end
    return 32'hFFFF_FFFF;
  endfunction

  task automatic op(input logic [1:0] sz, input bit w, input bit r, input logic [15:0] a,
                    input logic [31:0] d, input logic [2:0] dn, output logic [31:0] exp_rd);
    int e;
    logic [31:0] nctl, nsctl;
    logic [2:0]  oen, nen;
    @(negedge clk);
    bus_size = sz; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; chan_done = dn;
    exp_rd = m_read(sz, a);
    e = eff(a);
    nctl = m_ctl; nsctl = m_sctl;
    if (w) begin
      if (sz == 0 && e < 4) nctl[8*e +: 8] = d[7:0];
      if (sz == 0 && e >= 'h20 && e < 'h24) nsctl[8*(e-'h20) +: 8] = d[7:0];
      if (sz == 1 && e == 0) nctl[15:0] = d[15:0];
      if (sz == 1 && e == 2) nctl[31:16] = d[15:0];
      if (sz == 2 && e == 0) nctl = d;
      if (sz == 2 && e == 'h20) nsctl = d;
    end
    oen = m_sctl[10:8];
    nen = nsctl[10:8];
    @(posedge clk);
    #1;
    m_pend = (m_pend & ~(oen & ~nen)) | (dn & oen);
    m_ctl = nctl; m_sctl = nsctl;
    if (w) begin
      if ((sz == 0 || sz == 2) && e == 'h0C) m_page = d[3:0];
      if (sz == 1 && e == 'h10) m_codec = {16'h0, d[15:0]};
      if (sz != 0) begin
        if (e == 'h24) m_sc[0] = d[15:0];
        if (e == 'h28) m_sc[1] = d[15:0];
        if (e == 'h2C) m_sc[2] = d[15:0];
      end
      if (sz == 2) begin
        if (e == 'hC30) m_fa[0] = d;
        if (e == 'hC34) m_fc[0] = d;
        if (e == 'hC38) m_fa[1] = d;
        if (e == 'hC3C) m_fc[1] = d;
        if (e == 'hD30) m_fa[2] = d;
        if (e == 'hD34) m_fc[2] = d;
      end
    end
    bus_wr = 0; bus_rd = 0; chan_done = 0;
  endtask

  task automatic wr(input logic [1:0] sz, input logic [15:0] a, input logic [31:0] d);
    logic [31:0] x;
    op(sz, 1, 0, a, d, 3'b0, x);
  endtask

  task automatic rd(input string tag, input logic [1:0] sz, input logic [15:0] a,
                    input logic [31:0] lit);
    logic [31:0] x;
    op(sz, 0, 1, a, 0, 3'b0, x);
    chk({tag, " model"}, bus_rdata, x);
    chk({tag, " value"}, bus_rdata, lit);
  endtask

  task automatic pulse(input logic [2:0] dn);
    logic [31:0] x;
    op(2'd2, 0, 0, 16'h0, 0, dn, x);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R6 irq", {31'h0, irq}, {31'h0, (m_pend != 0)});
      chk("R3 ctl_out", ctl_out, m_ctl);
      chk("R3 sctl_out", sctl_out, m_sctl);
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    for (int i = 0; i < 3; i++) begin m_sc[i] = 0; m_fa[i] = 0; m_fc[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rd("R2 ctl", 2, 16'h00, 32'h1);
    rd("R2 status", 2, 16'h04, 32'h60);
    rd("R2 page", 2, 16'h0C, 32'h0);
    rd("R2 codec", 2, 16'h10, 32'h0);
    rd("R2 sctl", 2, 16'h20, 32'h0);
    chk("R2 irq", {31'h0, irq}, 32'h0);

    wr(0, 16'h02, 32'hFFFF_FFAB);
    rd("R3 ctl byte lane2", 2, 16'h00, 32'h00AB_0001);
    wr(1, 16'h02, 32'h0000_1234);
    rd("R3 ctl half hi", 2, 16'h00, 32'h1234_0001);
    wr(1, 16'h00, 32'hFFFF_5678);
    rd("R3 ctl half lo", 2, 16'h00, 32'h1234_5678);
    rd("R9 byte lane1", 0, 16'h01, 32'h56);
    wr(0, 16'h21, 32'h07);
    rd("R3 sctl byte lane1", 2, 16'h20, 32'h0700);
    wr(2, 16'h20, 32'h0);
    rd("R1 upper addr ignored", 2, 16'h1200, 32'h1234_5678);

    wr(2, 16'h0C, 32'h1F);
    rd("R4 page word", 2, 16'h0C, 32'hF);
    wr(0, 16'h0C, 32'hEC);
    rd("R4 page byte", 0, 16'h0C, 32'hC);

    wr(2, 16'h30, 32'hDEAD_BEEF);
    wr(2, 16'h34, 32'h0005_0010);
    rd("R5 dac1 faddr", 2, 16'h30, 32'hDEAD_BEEF);
    rd("R5 dac1 fcnt hi", 1, 16'h36, 32'h5);
    rd("R5 dac1 fcnt lo", 1, 16'h34, 32'h10);
    rd("R5 dac2 faddr reset", 2, 16'h38, 32'h0);
    wr(2, 16'h0C, 32'hD);
    wr(2, 16'h30, 32'h1357_9BDF);
    wr(2, 16'h38, 32'h0BAD_0BAD);
    wr(2, 16'h3C, 32'h0BAD_0BAD);
    rd("R5 phantom addr", 2, 16'h38, 32'hFFFF_FFFF);
    rd("R5 phantom cnt", 2, 16'h3C, 32'hFFFF_FFFF);
    rd("R5 adc faddr after phantom", 2, 16'h30, 32'h1357_9BDF);
    rd("R5 adc fcnt after phantom", 2, 16'h34, 32'h0);
    wr(2, 16'h0C, 32'h0);
    rd("R1 page0 window unmapped", 2, 16'h30, 32'hFFFF_FFFF);

    rd("R9 legacy byte", 0, 16'h1B, 32'h5);
    rd("R9 unmapped word", 2, 16'h08, 32'hFFFF_FFFF);
    rd("R9 unmapped half", 1, 16'h00, 32'hFFFF_FFFF);
    rd("R9 status byte0", 0, 16'h04, 32'h60);

    wr(2, 16'h28, 32'hFFFF_1234);
    rd("R10 dac2 count", 2, 16'h28, 32'h1234);
    rd("R10 current half", 1, 16'h2A, 32'h0);
    wr(1, 16'h2C, 32'h0000_00AA);
    rd("R10 adc count", 2, 16'h2C, 32'hAA);

    wr(1, 16'h10, 32'hBEEF_5A5A);
    rd("R11 codec", 2, 16'h10, 32'h5A5A);

    pulse(3'b111);
    chk("R7 no enable no irq", {31'h0, irq}, 32'h0);
    wr(2, 16'h20, 32'h100);
    pulse(3'b001);
    chk("R7 dac1 irq", {31'h0, irq}, 32'h1);
    rd("R6 status dac1", 2, 16'h04, 32'h8000_0064);
    pulse(3'b010);
    rd("R7 dac2 disabled", 2, 16'h04, 32'h8000_0064);
    wr(2, 16'h20, 32'h300);
    rd("R8 enable kept no clear", 2, 16'h04, 32'h8000_0064);
    wr(2, 16'h20, 32'h0);
    chk("R8 clear irq", {31'h0, irq}, 32'h0);
    rd("R8 status cleared", 2, 16'h04, 32'h60);

    wr(2, 16'h20, 32'h400);
    op(2, 1, 0, 16'h20, 32'h0, 3'b100, x);
    chk("R7 set beats clear", {31'h0, irq}, 32'h1);
    rd("R6 status adc", 2, 16'h04, 32'h8000_0061);
    rd("R6 status byte3", 0, 16'h07, 32'h80);
    wr(2, 16'h20, 32'h400);
    wr(0, 16'h21, 32'h00);
    chk("R8 byte write clears", {31'h0, irq}, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule